// File: doc/BRIEF.md
# Partner Multiframe Lag Monitor

The block watches a multiframe marker pulse that a partner device sends over a link and compares it with the local frame and multiframe timing. The partner pulse is asynchronous to the local clock. It passes through a two-flop synchroniser and a rising-edge detector. The block then measures the interval between successive partner edges in local clock cycles. It declares the partner timing trustworthy only after two edges land one multiframe apart, within one cycle.

A frame counter is cleared by the local multiframe pulse and advanced by the local frame pulse. When a correctly spaced partner edge arrives, the counter value is captured. It gives the number of whole 125 µs frames by which the partner marker trails the local one, from 0 to 47. The flag and the lag are presented together as one status byte. With the default parameters a frame is 16384 cycles of the 131.072 MHz clock, and a multiframe of 48 frames is 786432 cycles.

Top module: `partner_mf_lag_mon`

## Requirements
- R1: While and after the asynchronous reset, `status_o` reads 0x00.
- R2: A lone partner pulse never sets the flag (bit 7). The first synchronised edge after reset, or after a timeout, only serves as the reference for the next one.
- R3: The flag is set when a synchronised partner edge arrives between MF_CYC-1 and MF_CYC+1 cycles after the previous one. The status byte updates on the second clock edge after the edge that first samples `partner_i` high.
- R4: On a correctly spaced edge, bits 5..0 take the count of local frame pulses since the last local multiframe pulse, including the detection cycle. The count wraps after MF_FRAMES-1 (47), so the field never exceeds 47. Between such edges, bits 5..0 hold their value.
- R5: If the detection cycle coincides with a local multiframe pulse, the captured lag is 0. The multiframe pulse takes priority over a simultaneous frame pulse.
- R6: A partner edge whose spacing lies outside MF_CYC±1 clears the flag and leaves bits 5..0 unchanged.
- R7: If no partner edge arrives for MF_CYC+FRAME_CYC cycles, the flag clears. It sets again only after a new pair of correctly spaced edges.
- R8: Byte layout: bit 7 is the flag, bit 6 always reads 0, and bits 5..0 hold the lag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local clock (131.072 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Local frame pulse, one cycle per frame |
| mf_i | input | 1 | Local multiframe pulse, one cycle per multiframe |
| partner_i | input | 1 | Partner multiframe marker, asynchronous |
| status_o | output | 8 | {flag, 0, lag[5:0]} |

## Verification
A partner level first sampled high at clock edge c produces a detected edge at edge c+2. The flag, the lag capture and any spacing decision become visible after edge c+2. A timeout becomes visible after the edge at which MF_CYC+FRAME_CYC cycles have elapsed since the last detected edge. The bench reference model keeps a four-deep history of sampled partner values and cycle stamps of detected edges. It derives each result for the exact edge at which it is due. It then compares the whole status byte at the following falling edge on every cycle. Scenario checks are placed well clear of those edges, at chosen multiframe boundaries.

// File: rtl/plm_pkg.sv
`timescale 1ns/1ps
package plm_pkg;
  localparam int LAG_W = 6;

  typedef struct packed {
    logic             valid;
    logic             rsvd;
    logic [LAG_W-1:0] lag;
  } lag_status_t;
endpackage

// File: rtl/plm_edge_sync.sv
`timescale 1ns/1ps
module plm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/plm_frame_ctr.sv
`timescale 1ns/1ps
module plm_frame_ctr
  import plm_pkg::*;
#(
  parameter int MF_FRAMES = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             mf_i,
  output logic [LAG_W-1:0] cnt_nxt_o
);
  localparam logic [LAG_W-1:0] LAST = LAG_W'(MF_FRAMES - 1);

  logic [LAG_W-1:0] cnt_q;

  // multiframe marker overrides a coincident frame pulse
  always_comb begin
    if (mf_i)         cnt_nxt_o = '0;
    else if (frame_i) cnt_nxt_o = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    else              cnt_nxt_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
endmodule

// File: rtl/plm_gap_chk.sv
`timescale 1ns/1ps
module plm_gap_chk #(
  parameter int MF_CYC  = 786432,
  parameter int TIMEOUT = 802816,
  parameter int TOL     = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic pair_ok_o,
  output logic stale_o
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LO_C  = CNT_W'(MF_CYC - TOL);
  localparam logic [CNT_W-1:0] HI_C  = CNT_W'(MF_CYC + TOL);
  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(TIMEOUT);

  // 0 = no reference edge yet; saturates at SAT_C
  logic [CNT_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                          gap_q <= '0;
    else if (rise_i)                      gap_q <= CNT_W'(1);
    else if (gap_q != '0 && gap_q != SAT_C) gap_q <= gap_q + 1'b1;

  assign pair_ok_o = rise_i && (gap_q >= LO_C) && (gap_q <= HI_C);
  assign stale_o   = (gap_q == SAT_C);
endmodule

// File: rtl/partner_mf_lag_mon.sv
`timescale 1ns/1ps
module partner_mf_lag_mon
  import plm_pkg::*;
#(
  parameter int FRAME_CYC   = 16384,
  parameter int MF_FRAMES   = 48,
  parameter int TOL         = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_i,
  input  logic       mf_i,
  input  logic       partner_i,
  output logic [7:0] status_o
);
  localparam int MF_CYC  = FRAME_CYC * MF_FRAMES;
  localparam int TIMEOUT = MF_CYC + FRAME_CYC;

  logic             rise;
  logic             pair_ok;
  logic             stale;
  logic [LAG_W-1:0] lag_nxt;
  logic             valid_q;
  logic [LAG_W-1:0] lag_q;
  lag_status_t      stat;

  plm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(partner_i), .rise_o(rise)
  );

  plm_frame_ctr #(.MF_FRAMES(MF_FRAMES)) u_frm (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .mf_i(mf_i),
    .cnt_nxt_o(lag_nxt)
  );

  plm_gap_chk #(.MF_CYC(MF_CYC), .TIMEOUT(TIMEOUT), .TOL(TOL)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise),
    .pair_ok_o(pair_ok), .stale_o(stale)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      valid_q <= 1'b0;
      lag_q   <= '0;
    end else if (rise) begin
      valid_q <= pair_ok;
      if (pair_ok) lag_q <= lag_nxt;
    end else if (stale) begin
      valid_q <= 1'b0;
    end

  always_comb begin
    stat.valid = valid_q;
    stat.rsvd  = 1'b0;
    stat.lag   = lag_q;
  end

  assign status_o = stat;
endmodule

// File: rtl/partner_mf_lag_mon_chk.sv
`timescale 1ns/1ps
module partner_mf_lag_mon_chk #(
  parameter int FRAME_CYC = 16384,
  parameter int MF_FRAMES = 48
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       partner_i,
  input logic [7:0] status_o
);
  localparam int          TIMEOUT = FRAME_CYC * MF_FRAMES + FRAME_CYC;
  localparam int unsigned LIM     = TIMEOUT + 4;

  logic        p_d;
  int unsigned quiet;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      p_d   <= 1'b0;
      quiet <= 0;
    end else begin
      p_d <= partner_i;
      if (partner_i && !p_d) quiet <= 0;
      else if (quiet < LIM)  quiet <= quiet + 1;
    end

  // R3
  flag_rise_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[7]) |-> ($past(partner_i, 3) && !$past(partner_i, 4)));

  // R4
  lag_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5:0] < 6'(MF_FRAMES));

  // R6
  lag_moves_only_when_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_o[5:0]) |-> status_o[7]);

  // R7
  quiet_link_drops_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet >= LIM) |-> !status_o[7]);
endmodule

bind partner_mf_lag_mon partner_mf_lag_mon_chk #(
  .FRAME_CYC(FRAME_CYC), .MF_FRAMES(MF_FRAMES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .partner_i(partner_i), .status_o(status_o)
);

// File: tb/partner_mf_lag_mon_bench.sv
`timescale 1ns/1ps
module partner_mf_lag_mon_bench;
  localparam int F   = 16;
  localparam int NF  = 48;
  localparam int MF  = F * NF;
  localparam int TO  = MF + F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_i = 1'b0, mf_i = 1'b0, partner_i = 1'b0;
  logic [7:0] status_o;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit p_en = 0;
  int next_p = 0, period = MF, hi = 0;
  string cur_req = "R1";

  // reference model state
  bit hist[$];
  int fr = 0, last = -1, m = 0;
  bit exp_v = 0;
  int exp_lag = 0;

  always #5 clk = ~clk;

  partner_mf_lag_mon #(.FRAME_CYC(F), .MF_FRAMES(NF)) u_partner_mf_lag_mon (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame_i), .mf_i(mf_i),
    .partner_i(partner_i), .status_o(status_o)
  );

  // stimulus driver: values for posedge number cyc
  always @(negedge clk) begin
    if (rst_n) begin
      frame_i = (cyc % F == 0);
      mf_i    = (cyc % MF == 0);
      if (p_en && cyc == next_p) begin
        hi = 3;
        next_p = next_p + period;
      end
      partner_i = (hi > 0);
      if (hi > 0) hi = hi - 1;
      cyc = cyc + 1;
    end
  end

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      fr = 0; last = -1; m = 0; exp_v = 0; exp_lag = 0;
    end else begin
      bit det;
      int d;
      hist.push_back(partner_i);
      det = hist[1] && !hist[0];
      void'(hist.pop_front());
      if (mf_i) fr = 0;
      else if (frame_i) fr = (fr + 1) % NF;
      if (det) begin
        d = (last < 0) ? -1000 : m - last;
        exp_v = (d >= MF - 1 && d <= MF + 1);
        if (exp_v) exp_lag = fr;
        last = m;
      end else if (last >= 0 && m - last >= TO) begin
        exp_v = 0;
      end
      m = m + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] e;
      e = {exp_v, 1'b0, 6'(exp_lag)};
      checks++;
      if (status_o !== e) begin
        fails++;
        $display("FAIL %s model cycle %0d: status=%02h expected=%02h", cur_req, cyc, status_o, e);
      end
    end
  end

  task automatic chk(string req, logic [7:0] mask, logic [7:0] exp);
    checks++;
    if ((status_o & mask) !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: status=%02h expected=%02h (mask %02h)", req, cyc, status_o & mask, exp, mask);
    end
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
    #1;
  endtask

  task automatic set_sched(bit en, int np, int per);
    @(posedge clk);
    #1;
    p_en = en; next_p = np; period = per;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", 8'hFF, 8'h00);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", 8'hFF, 8'h00);

    // lag 5, first pulse alone is not enough
    cur_req = "R2 R3";
    set_sched(1, MF + 83, MF);
    wait_cyc(1000);
    chk("R2", 8'h80, 8'h00);
    wait_cyc(MF * 5);
    chk("R3 R8", 8'hFF, 8'h85);

    // detection on the local multiframe pulse
    cur_req = "R5";
    set_sched(1, MF * 6 + 766, MF);
    wait_cyc(MF * 9 + 100);
    chk("R5", 8'hFF, 8'h80);

    // last frame of the multiframe
    cur_req = "R4";
    set_sched(1, MF * 11 + 760, MF);
    wait_cyc(MF * 14);
    chk("R4", 8'hFF, 8'hAF);

    // spacing tolerance
    cur_req = "R6";
    set_sched(1, next_p, MF + 1);
    wait_cyc(13100);
    chk("R6", 8'h80, 8'h80);
    set_sched(1, next_p, MF + 2);
    wait_cyc(14650);
    chk("R6", 8'h80, 8'h00);
    set_sched(1, next_p, MF);
    wait_cyc(16200);
    chk("R6", 8'h80, 8'h80);

    // silent partner
    cur_req = "R7";
    set_sched(0, next_p, MF);
    wait_cyc(16800);
    chk("R7", 8'h80, 8'h80);
    wait_cyc(17000);
    chk("R7", 8'h80, 8'h00);
    set_sched(1, 17700, MF);
    wait_cyc(17800);
    chk("R7", 8'h80, 8'h00);
    wait_cyc(18600);
    chk("R7 R4", 8'hFF, 8'h82);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 10);
    fails++;
    $display("FAIL watchdog expired at cycle %0d (expected finish before 100000)", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule